// File: doc/BRIEF.md
# Dual-Law SPI Bit-Clock Divider

This block turns the module clock into the timing reference for an SPI shift engine. It emits a single-cycle tick once per SCLK half-period, so the shift engine gets one tick for each SCLK edge. It also drives a 50% duty SCLK level that toggles on each tick. The division ratio comes from one write-only clock control register, which the block decodes from a simple write port.

The register holds two divide settings and a law select bit. The linear law gives SCLK = module clock / (2*(N+1)) with an 8-bit N. The power-of-two law gives SCLK = module clock / 2^(N+1) with a 4-bit N. Under either law SCLK is at most half the module clock.

Any write to the register restarts the divider from a known phase, so a new setting starts a clean period. While the controller enable input is low, the divider is held idle.

Top module: `spi_clk_divider`

## Requirements
- R1: The clock control register is decoded at byte offset 0x1C of the write port. A write to any other offset leaves the divider's period and phase unchanged.
- R2: In the written word, bit 12 selects the law (1 = linear, 0 = power-of-two). Bits 7:0 hold the linear N and bits 11:8 hold the power-of-two N. All other data bits have no effect.
- R3: In linear mode a tick occurs every N+1 module clocks, giving SCLK = clk/(2*(N+1)). N = 0 gives a tick on every cycle, which is SCLK at exactly half the module clock.
- R4: In power-of-two mode a tick occurs every 2^N module clocks, giving SCLK = clk/2^(N+1). This holds for N = 0 through N = 15.
- R5: SCLK toggles on each tick and changes at no other time except when it is forced low. It is high for exactly P cycles out of every 2P, where P is the tick period.
- R6: A write to the register forces SCLK low and restarts the count. The first tick is produced by the P-th rising edge after the edge that stores the write.
- R7: While the enable input is low there are no ticks and SCLK stays low. After enable rises, the first tick is produced by the P-th edge, counting the first edge at which enable is seen high as the first.
- R8: After reset the register is zero (power-of-two law, N = 0), and the tick and SCLK outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| coreEnable | input | 1 | Controller enable; low holds the divider idle |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Byte offset of the write |
| regWrData | input | 32 | Write data |
| sclkTick | output | 1 | One-cycle pulse per SCLK half-period |
| sclkOut | output | 1 | 50% duty SCLK level |

## Verification
The embedded properties check several rules on every cycle. The spacing between consecutive ticks must match the selected law. The counter must stay within its terminal value. SCLK may only move on a tick or when forced low. The outputs must stay quiet during hold and immediately after a reload. The register must not change without a write. Only the bench's scenarios can show four things. They show that the register fields sit at the stated bit positions and that writes to other offsets are ignored. They show the exact latency from a write or from enable to the first tick. They also confirm the extreme settings: linear N = 0 and 255, and power-of-two N = 0 and 15.

// File: rtl/spi_clk_divider_pkg.sv
package spi_clk_divider_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic hold;    // divider idle, outputs low
    logic reload;  // register written, restart phase
  } divStrobe_t;
endpackage

// File: rtl/spi_clk_div_ctrl.sv
module spi_clk_div_ctrl
  import spi_clk_divider_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 'h1C,
  parameter int LIN_W      = 8,
  parameter int EXP_W      = 4,
  parameter int EXP_LSB    = 8,
  parameter int SEL_BIT    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreEnable,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output divStrobe_t        strobe,
  output logic              linSel,
  output logic [LIN_W-1:0]  linDiv,
  output logic [EXP_W-1:0]  expDiv
);
  localparam logic [DATA_W-1:0] LIN_MASK  = DATA_W'((1 << LIN_W) - 1);
  localparam logic [DATA_W-1:0] EXP_MASK  = DATA_W'(((1 << EXP_W) - 1) << EXP_LSB);
  localparam logic [DATA_W-1:0] SEL_MASK  = DATA_W'(1) << SEL_BIT;
  localparam logic [DATA_W-1:0] USED_MASK = LIN_MASK | EXP_MASK | SEL_MASK;

  logic regHit;
  logic unusedWrBits;

  assign regHit       = regWrEn && (regAddr == ADDR_W'(REG_OFFSET));
  assign unusedWrBits = ^(regWrData & ~USED_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      linSel <= 1'b0;
      linDiv <= '0;
      expDiv <= '0;
    end else if (regHit) begin
      linSel <= regWrData[SEL_BIT];
      linDiv <= regWrData[LIN_W-1:0];
      expDiv <= regWrData[EXP_LSB +: EXP_W];
    end
  end

  always_comb begin
    strobe.hold   = !coreEnable;
    strobe.reload = regHit;
  end

  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> ($stable(linSel) && $stable(linDiv) && $stable(expDiv)));
endmodule

// File: rtl/spi_clk_div_datapath.sv
module spi_clk_div_datapath
  import spi_clk_divider_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strobe,
  input  logic             linSel,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [EXP_W-1:0] expDiv,
  output logic             tickQ,
  output logic             sclkQ
);
  localparam int EXP_SPAN = 1 << EXP_W;
  localparam int CNT_W    = (EXP_SPAN > LIN_W) ? EXP_SPAN : LIN_W;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             atLimit;

  // Terminal count: N for linear, 2^N - 1 for power-of-two
  always_comb begin
    if (linSel) limit = CNT_W'(linDiv);
    else        limit = (CNT_W'(1) << expDiv) - CNT_W'(1);
  end

  assign atLimit = (cnt == limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt   <= '0;
      tickQ <= 1'b0;
      sclkQ <= 1'b0;
    end else if (strobe.hold || strobe.reload) begin
      cnt   <= '0;
      tickQ <= 1'b0;
      sclkQ <= 1'b0;
    end else if (atLimit) begin
      cnt   <= '0;
      tickQ <= 1'b1;
      sclkQ <= !sclkQ;
    end else begin
      cnt   <= cnt + CNT_W'(1);
      tickQ <= 1'b0;
    end
  end

  // Independent spacing monitor: edges since the last restart or tick
  logic [CNT_W:0] gapCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              gapCnt <= '0;
    else if (strobe.hold || strobe.reload)  gapCnt <= '0;
    else if (tickQ)                         gapCnt <= (CNT_W+1)'(1);
    else if (gapCnt != '1)                  gapCnt <= gapCnt + (CNT_W+1)'(1);
  end

  // R3 (and R4): tick spacing equals the selected period
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ && !$past(strobe.hold)) |-> (gapCnt == ({1'b0, limit} + (CNT_W+1)'(1)) || gapCnt == ({1'b0, limit} + (CNT_W+1)'(2))));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    $stable(limit) |-> (cnt <= limit));

  // R5
  sclk_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclkQ) |-> (tickQ || !sclkQ));

  // R6
  reload_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.reload |=> (!tickQ && !sclkQ && cnt == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.hold |=> (!tickQ && !sclkQ));
endmodule

// File: rtl/spi_clk_divider.sv
module spi_clk_divider
  import spi_clk_divider_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int REG_OFFSET = 'h1C,
  parameter int LIN_W      = 8,
  parameter int EXP_W      = 4,
  parameter int EXP_LSB    = 8,
  parameter int SEL_BIT    = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coreEnable,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              sclkTick,
  output logic              sclkOut
);
  divStrobe_t       strobe;
  logic             linSel;
  logic [LIN_W-1:0] linDiv;
  logic [EXP_W-1:0] expDiv;

  spi_clk_div_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET),
    .LIN_W(LIN_W), .EXP_W(EXP_W), .EXP_LSB(EXP_LSB), .SEL_BIT(SEL_BIT)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .coreEnable(coreEnable),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .strobe(strobe), .linSel(linSel), .linDiv(linDiv), .expDiv(expDiv)
  );

  spi_clk_div_datapath #(
    .LIN_W(LIN_W), .EXP_W(EXP_W)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .linSel(linSel), .linDiv(linDiv), .expDiv(expDiv),
    .tickQ(sclkTick), .sclkQ(sclkOut)
  );

  // R8
  always_ff @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!sclkTick && !sclkOut);
    end
  end
endmodule

// File: tb/tb_spi_clk_divider.sv
module tb_spi_clk_divider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        coreEnable = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        sclkTick;
  logic        sclkOut;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  spi_clk_divider dut (
    .clk(clk), .rstN(rstN), .coreEnable(coreEnable),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .sclkTick(sclkTick), .sclkOut(sclkOut)
  );

  function automatic int expPeriod(bit sel, int lin, int ex);
    return sel ? (lin + 1) : (1 << ex);
  endfunction

  function automatic logic [31:0] packCfg(bit sel, int lin, int ex, logic [31:0] junk);
    return (junk & ~32'h1FFF) | (32'(sel) << 12) | (32'(ex & 15) << 8) | 32'(lin & 255);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
  endtask

  // counts negedges after the storing edge until the first tick
  task automatic firstTick(output int k, output int earlyHigh);
    k = 0; earlyHigh = 0;
    do begin
      @(negedge clk);
      k++;
      if (!sclkTick && sclkOut) earlyHigh++;
    end while (!sclkTick && k < 70000);
  endtask

  // called at a negedge where a tick is seen: scan 2P cycles
  task automatic dutyScan(int p, output int highs, output int ticks);
    highs = 0; ticks = 0;
    for (int i = 0; i < 2 * p; i++) begin
      if (sclkOut) highs++;
      if (sclkTick) ticks++;
      @(negedge clk);
    end
  endtask

  task automatic gapMeasure(output int k);
    k = 0;
    while (!sclkTick) @(negedge clk);
    do begin
      @(negedge clk);
      k++;
    end while (!sclkTick && k < 70000);
  endtask

  task automatic runVector(string req, bit sel, int lin, int ex, logic [31:0] junk, bit doDuty);
    int k, early, highs, ticks, p;
    p = expPeriod(sel, lin, ex);
    regWrite(8'h1C, packCfg(sel, lin, ex, junk));
    firstTick(k, early);
    check(k == p + 1, {req, " R6 first tick"}, k, p + 1);
    check(early == 0, {req, " R6 sclk low before tick"}, early, 0);
    if (doDuty) begin
      dutyScan(p, highs, ticks);
      check(highs == p && ticks == 2, {req, " R5 duty"}, highs, p);
    end
  endtask

  initial begin
    #(1900000);
    if (!done) begin
      nFail++;
      nChecks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int k, early, cnt, highs, ticks;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R8: outputs low during reset
    check(!sclkTick && !sclkOut, "R8 reset outputs", {sclkTick, sclkOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    // R7: enable low keeps outputs quiet
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclkTick || sclkOut) cnt++;
    end
    check(cnt == 0, "R7 idle after reset", cnt, 0);
    // R8: default setting is power-of-two N=0 -> tick every cycle
    coreEnable = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!sclkTick && k < 100);
    check(k == 1, "R8 default period", k, 1);
    dutyScan(1, highs, ticks);
    check(highs == 1 && ticks == 2, "R8 R5 default duty", highs, 1);

    // R3 corner: linear N=0 and N=255
    runVector("R3 lin0", 1'b1, 0, 0, 32'h0, 1'b1);
    runVector("R3 lin255", 1'b1, 255, 0, 32'h0, 1'b1);
    // R4 corners: N=0 and N=15
    runVector("R4 exp0", 1'b0, 0, 0, 32'h0, 1'b1);
    runVector("R4 exp15", 1'b0, 0, 15, 32'h0, 1'b0);

    // R2: junk in unused bits and in the other law's field has no effect
    runVector("R2 junk lin", 1'b1, 6, 9, 32'hFFFF_E000, 1'b1);
    runVector("R2 junk exp", 1'b0, 200, 3, 32'hA5A5_E000, 1'b1);

    // R1: write to another offset leaves period unchanged
    regWrite(8'h1C, packCfg(1'b1, 3, 0, 32'h0));
    regWrite(8'h18, packCfg(1'b1, 9, 0, 32'h0));
    regWrite(8'h1D, packCfg(1'b0, 0, 5, 32'h0));
    gapMeasure(k);
    check(k == 4, "R1 other offset ignored", k, 4);
    gapMeasure(k);
    check(k == 4, "R1 period steady", k, 4);

    // R7: disable then re-enable
    regWrite(8'h1C, packCfg(1'b1, 4, 0, 32'h0));
    @(negedge clk);
    coreEnable = 1'b0;
    @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (sclkTick || sclkOut) cnt++;
      @(negedge clk);
    end
    check(cnt == 0, "R7 hold quiet", cnt, 0);
    coreEnable = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!sclkTick && k < 100);
    check(k == 5, "R7 first tick after enable", k, 5);

    // R3/R4 random vectors
    for (int v = 0; v < 14; v++) begin
      bit sel;
      int lin, ex;
      sel = 1'($urandom % 2);
      lin = int'($urandom % 256);
      ex  = int'($urandom % 9);
      runVector(sel ? "R3 rand" : "R4 rand", sel, lin, ex, $urandom, 1'b1);
    end

    // R6: rewrite mid-period restarts phase
    regWrite(8'h1C, packCfg(1'b1, 20, 0, 32'h0));
    repeat (7) @(negedge clk);
    runVector("R6 restart", 1'b1, 2, 0, 32'h0, 1'b1);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule